// File: doc/BRIEF.md
# Clause 45 MDIO Management Controller

This block lets software reach the management registers of PHY devices over a two-wire Clause 45 bus. Software first programs a clock divider and a port/device address pair. It then writes one of three registers, and each write launches a complete serial frame on the bus. Writing the register-number register sends an address frame. Writing the data register sends a write frame. Writing the control register with its read trigger sends a read frame.

The controller derives MDC from the system clock. It shifts frames out MSB first through a pad interface with separate output, output-enable and input pins. During the read turnaround it releases the line and captures the PHY's reply. Two busy flags show which kind of frame is running. While either flag is set, any write that would launch another frame is dropped. A read that gets no answer from the bus sets an error flag.

Top module: `mdio45_ctrl`

## Requirements
- R1: After synchronous reset, all registers read 0: both busy flags (status bit 31 and data bit 31) are clear, the read-error flag (status bit 30) is clear, MDC is low and the MDIO output enable is low.
- R2: Writing the register-number register (offset 2) while idle starts an address frame with opcode 00. Status bit 31 reads 1 from the next cycle until the frame ends, and data bit 31 stays 0 throughout.
- R3: Writing the data register (offset 3) while idle starts a write frame with opcode 01 that carries bits 15:0 of the written value. Data bit 31 reads 1 until the frame ends, and status bit 31 stays 0.
- R4: Writing the control register (offset 1) with bit 31 set while idle starts a read frame with opcode 11. The frame uses the port and device addresses from that same write. Data bit 31 reads 1 until the frame ends.
- R5: Each frame has 64 bits, sent MSB first: 32 ones, then start bits 00, the 2-bit opcode, the 5-bit port address, the 5-bit device address, 2 turnaround bits (10 when the controller drives them), and 16 bits of register number or data.
- R6: MDC is low when idle, and each half period lasts N system clocks. N is status bits 7:0, latched when a frame starts, and a value of 0 acts as 1. A divider write during a frame is accepted but only takes effect from the next frame.
- R7: In a read frame, the MDIO output enable is low from the first turnaround bit to the end of the frame. In address and write frames it stays high for the whole frame.
- R8: After a read frame, data bits 15:0 hold the 16 bits sampled on the MDC rising edges that follow the turnaround.
- R9: Status bit 30 is set when the second turnaround bit of a read is sampled as 1. It is cleared when a read frame starts, and it stays 0 when a PHY drives that bit to 0.
- R10: While either busy flag is set, writes to the control, register-number and data registers are ignored. They launch no frame and leave the readback values unchanged.
- R11: The control register reads back the port address in bits 4:0 and the device address in bits 12:8. Bit 31 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset (0 status, 1 control, 2 register number, 3 data) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the register selected by bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
A stuck or miscounting bit index shows up at the end of the frame. The bench captures every frame on the wire and compares all 64 bits with the frame queued at launch, so a lost, extra or shifted bit is reported within one frame time. Errors in the divider latch or the MDC phase show up as a wrong spacing between the last two MDC rises, measured on every frame. A busy flag that is wrong, or a write that leaks through while busy, shows up as an unexpected frame or a changed register readback right after the frame ends. A wrong turnaround release shows up at bit 46 of any read.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    // index of first turnaround bit: preamble + start + opcode + two 5-bit addresses
    localparam int TA_IDX     = PRE_BITS + 2 + 2 + 5 + 5;
    localparam int DATA_IDX   = TA_IDX + 2;

    localparam logic [1:0] OFS_STAT = 2'd0;
    localparam logic [1:0] OFS_CTRL = 2'd1;
    localparam logic [1:0] OFS_REGN = 2'd2;
    localparam logic [1:0] OFS_DATA = 2'd3;

    // enum values equal the opcode sent on the wire
    typedef enum logic [1:0] {
        K_ADDR  = 2'b00,
        K_WRITE = 2'b01,
        K_READ  = 2'b11
    } frame_kind_e;

    typedef struct packed {
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] payload;
    } frame_hdr_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(frame_kind_e k, frame_hdr_t h);
        logic [1:0]  ta;
        logic [15:0] body;
        ta   = (k == K_READ) ? 2'b11 : 2'b10;
        body = (k == K_READ) ? 16'hFFFF : h.payload;
        return {{PRE_BITS{1'b1}}, 2'b00, logic'(k[1]), logic'(k[0]), h.port, h.dev, ta, body};
    endfunction

endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap   = run_i && (cnt_q == lim_q - 1'b1);
    assign rise_o = wrap && !mdc_q;
    assign fall_o = wrap && mdc_q;
    assign mdc_o  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= '0;
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run_i) begin
            lim_q <= (div_i == '0) ? DIV_W'(1) : div_i;
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: clock parks low whenever no frame runs
    a_r6_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !mdc_q);
    // R6: divider latched while running never changes mid-frame
    a_r6_lim_stable: assert property (@(posedge clk) disable iff (rst)
        run_i && $past(run_i) |-> $stable(lim_q));

endmodule

// File: rtl/mdio45_engine.sv
module mdio45_engine
    import mdio45_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  frame_kind_e start_kind_i,
    input  frame_hdr_t  start_hdr_i,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        mdio_i,
    output logic        active_o,
    output frame_kind_e kind_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    output logic        done_o,
    output logic [15:0] rd_word_o,
    output logic        rd_err_o
);
    logic                  active_q;
    frame_kind_e           kind_q;
    logic [5:0]            idx_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [15:0]           rd_q;
    logic                  err_q;
    logic                  released;

    assign released  = (kind_q == K_READ) && (idx_q >= 6'(TA_IDX));
    assign active_o  = active_q;
    assign kind_o    = kind_q;
    assign mdio_o    = sh_q[FRAME_BITS-1];
    assign mdio_oe_o = active_q && !released;
    assign done_o    = active_q && fall_i && (idx_q == 6'(FRAME_BITS-1));
    assign rd_word_o = rd_q;
    assign rd_err_o  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            kind_q   <= K_ADDR;
            idx_q    <= '0;
            sh_q     <= '0;
            rd_q     <= '0;
            err_q    <= 1'b0;
        end else if (start_i && !active_q) begin
            active_q <= 1'b1;
            kind_q   <= start_kind_i;
            idx_q    <= '0;
            sh_q     <= build_frame(start_kind_i, start_hdr_i);
            rd_q     <= '0;
            err_q    <= 1'b0;
        end else if (active_q) begin
            if (rise_i && kind_q == K_READ) begin
                if (idx_q == 6'(TA_IDX + 1))
                    err_q <= mdio_i;
                if (idx_q >= 6'(DATA_IDX))
                    rd_q <= {rd_q[14:0], mdio_i};
            end
            if (fall_i) begin
                if (idx_q == 6'(FRAME_BITS-1)) begin
                    active_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    // R10: the register file never launches a frame on top of a running one
    a_r10_start_only_idle: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !active_q);
    // R5: bit position only moves on an MDC falling edge
    a_r5_idx_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        active_q && !fall_i |=> $stable(idx_q));
    // R6: rising and falling strobes are exclusive
    a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rise_i && fall_i));

endmodule

// File: rtl/mdio45_regs.sv
module mdio45_regs
    import mdio45_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [1:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    input  logic             stat_busy_i,
    input  logic             data_busy_i,
    input  logic             done_i,
    input  frame_kind_e      kind_i,
    input  logic [15:0]      rd_word_i,
    input  logic             rd_err_i,
    output logic             start_o,
    output frame_kind_e      start_kind_o,
    output frame_hdr_t       start_hdr_o,
    output logic [DIV_W-1:0] div_o
);
    logic [DIV_W-1:0] div_q;
    logic [4:0]       port_q;
    logic [4:0]       dev_q;
    logic [15:0]      regn_q;
    logic [15:0]      data_q;
    logic             rderr_q;
    logic             idle;
    logic             unused_wbits;

    assign idle         = !stat_busy_i && !data_busy_i;
    assign div_o        = div_q;
    assign unused_wbits = ^wdata_i[30:16];

    always_comb begin
        start_o      = 1'b0;
        start_kind_o = K_ADDR;
        start_hdr_o  = '{port: port_q, dev: dev_q, payload: wdata_i[15:0]};
        if (we_i && idle) begin
            case (addr_i)
                OFS_REGN: begin
                    start_o      = 1'b1;
                    start_kind_o = K_ADDR;
                end
                OFS_DATA: begin
                    start_o      = 1'b1;
                    start_kind_o = K_WRITE;
                end
                OFS_CTRL: begin
                    start_o      = wdata_i[31];
                    start_kind_o = K_READ;
                    start_hdr_o  = '{port: wdata_i[4:0], dev: wdata_i[12:8], payload: 16'hFFFF};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            port_q  <= '0;
            dev_q   <= '0;
            regn_q  <= '0;
            data_q  <= '0;
            rderr_q <= 1'b0;
        end else begin
            if (we_i && addr_i == OFS_STAT)
                div_q <= wdata_i[DIV_W-1:0];
            if (we_i && idle) begin
                case (addr_i)
                    OFS_CTRL: begin
                        port_q <= wdata_i[4:0];
                        dev_q  <= wdata_i[12:8];
                    end
                    OFS_REGN: regn_q <= wdata_i[15:0];
                    OFS_DATA: data_q <= wdata_i[15:0];
                    default: ;
                endcase
            end
            if (start_o && start_kind_o == K_READ)
                rderr_q <= 1'b0;
            if (done_i && kind_i == K_READ) begin
                data_q  <= rd_word_i;
                rderr_q <= rd_err_i;
            end
        end
    end

    always_comb begin
        case (addr_i)
            OFS_STAT: rdata_o = {stat_busy_i, rderr_q, 30'(div_q)};
            OFS_CTRL: rdata_o = {19'b0, dev_q, 3'b0, port_q};
            OFS_REGN: rdata_o = {16'b0, regn_q};
            default:  rdata_o = {data_busy_i, 15'b0, data_q};
        endcase
    end

    // R9: starting a read always leaves the error flag clear
    a_r9_err_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        start_o && start_kind_o == K_READ |=> !rderr_q);
    // R10: number register is frozen while a frame runs
    a_r10_regn_frozen: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(regn_q));

endmodule

// File: rtl/mdio45_ctrl.sv
module mdio45_ctrl
    import mdio45_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic             active, done, start, rise, fall, rd_err;
    logic             stat_busy, data_busy;
    frame_kind_e      kind, start_kind;
    frame_hdr_t       start_hdr;
    logic [15:0]      rd_word;
    logic [DIV_W-1:0] div;

    assign stat_busy = active && (kind == K_ADDR);
    assign data_busy = active && (kind != K_ADDR);

    mdio45_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .stat_busy_i(stat_busy), .data_busy_i(data_busy),
        .done_i(done), .kind_i(kind), .rd_word_i(rd_word), .rd_err_i(rd_err),
        .start_o(start), .start_kind_o(start_kind), .start_hdr_o(start_hdr),
        .div_o(div)
    );

    mdio45_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .run_i(active), .div_i(div),
        .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
    );

    mdio45_engine u_eng (
        .clk(clk), .rst(rst), .start_i(start), .start_kind_i(start_kind),
        .start_hdr_i(start_hdr), .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
        .active_o(active), .kind_o(kind), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
        .done_o(done), .rd_word_o(rd_word), .rd_err_o(rd_err)
    );

    // R2: at most one busy flag at a time
    a_r2_one_busy: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stat_busy, data_busy}));
    // R7: pad is only driven inside a frame
    a_r7_oe_inside_frame: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> (stat_busy || data_busy));

endmodule

// File: tb/tb_mdio45_ctrl.sv
`timescale 1ns/1ps
module tb_mdio45_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_bus;

    logic        drv_en = 1'b0;
    logic        drv_bit = 1'b1;
    logic        respond = 1'b0;
    logic [15:0] phy_val = '0;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [63:0] frame;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = !clk;

    assign mdio_bus = mdio_oe ? mdio_o : (drv_en ? drv_bit : 1'b1);

    mdio45_ctrl dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_bus), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- bus model / monitor ----------------
    logic [63:0] cap = '0;
    int          rises = 0;
    logic        is_rd = 1'b0;
    int          frames_seen = 0;
    realtime     t_prev = 0;
    realtime     last_period = 0;

    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_bus};
        rises++;
        if (rises == 36) is_rd = (cap[1:0] == 2'b11);
        if (rises == 47) check("R7", {63'b0, mdio_oe}, {63'b0, !is_rd});
        if (rises == 63) t_prev = $realtime;
        if (rises == 64) begin
            last_period = $realtime - t_prev;
            frames_seen++;
            if (exp_q.size() == 0) begin
                check("R10", cap, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, cap, e.frame);
            end
            rises = 0;
            is_rd = 1'b0;
        end
    end

    // PHY responder: drives after MDC falls, for bit index == rises
    always @(negedge mdc) begin
        if (is_rd && respond && rises >= 47 && rises < 64) begin
            drv_en  <= 1'b1;
            drv_bit <= (rises == 47) ? 1'b0 : phy_val[63 - rises];
        end else begin
            drv_en  <= 1'b0;
        end
    end

    // ---------------- driver ----------------
    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s, dt;
        for (int i = 0; i < 40000; i++) begin
            reg_read(2'd0, s);
            reg_read(2'd3, dt);
            if (!s[31] && !dt[31]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [63:0] frm(logic [1:0] op, logic [4:0] p, logic [4:0] d,
                                        logic [1:0] ta, logic [15:0] body);
        return {32'hFFFF_FFFF, 2'b00, op, p, d, ta, body};
    endfunction

    task automatic expect_frame(logic [63:0] f, string req);
        exp_t e;
        e.frame = f; e.req = req;
        exp_q.push_back(e);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] r;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        reg_read(2'd0, r); check("R1", {32'b0, r}, 64'h0);
        reg_read(2'd3, r); check("R1", {32'b0, r}, 64'h0);
        check("R1", {62'b0, mdc, mdio_oe}, 64'h0);

        // R11 control readback, read bit not stored
        reg_write(2'd0, 32'd3);
        reg_write(2'd1, 32'h0000_0712);
        reg_read(2'd1, r); check("R11", {32'b0, r}, 64'h0000_0712);

        // R2 address frame, plus R10 ignored writes and R6 divider latch
        expect_frame(frm(2'b00, 5'h12, 5'h07, 2'b10, 16'hA5C3), "R2/R5");
        reg_write(2'd2, 32'h0000_A5C3);
        reg_read(2'd0, r); check("R2", {63'b0, r[31]}, 64'h1);
        reg_read(2'd3, r); check("R2", {63'b0, r[31]}, 64'h0);
        reg_write(2'd3, 32'h0000_1234);
        reg_write(2'd2, 32'h0000_5555);
        reg_write(2'd1, 32'h8000_0101);
        reg_write(2'd0, 32'd4);
        wait_idle();
        check("R6", 64'(int'(last_period)), 64'd120);
        check("R6", {63'b0, mdc}, 64'h0);
        reg_read(2'd2, r); check("R10", {32'b0, r}, 64'h0000_A5C3);
        reg_read(2'd3, r); check("R10", {32'b0, r}, 64'h0);
        reg_read(2'd1, r); check("R10", {32'b0, r}, 64'h0000_0712);
        reg_read(2'd0, r); check("R6", {32'b0, r}, 64'd4);

        // R3 write frame at divider 4
        expect_frame(frm(2'b01, 5'h12, 5'h07, 2'b10, 16'hBEEF), "R3/R5");
        reg_write(2'd3, 32'h0000_BEEF);
        reg_read(2'd3, r); check("R3", {32'b0, r}, 64'h8000_BEEF);
        reg_read(2'd0, r); check("R3", {63'b0, r[31]}, 64'h0);
        wait_idle();
        check("R6", 64'(int'(last_period)), 64'd160);

        // R4/R8 read with a responding PHY
        reg_write(2'd0, 32'd2);
        respond = 1'b1; phy_val = 16'h3C5A;
        expect_frame(frm(2'b11, 5'h0A, 5'h1E, 2'b10, 16'h3C5A), "R4/R5");
        reg_write(2'd1, 32'h8000_1E0A);
        reg_read(2'd3, r); check("R4", {63'b0, r[31]}, 64'h1);
        wait_idle();
        reg_read(2'd3, r); check("R8", {32'b0, r}, 64'h0000_3C5A);
        reg_read(2'd0, r); check("R9", {62'b0, r[31:30]}, 64'h0);
        reg_read(2'd1, r); check("R11", {32'b0, r}, 64'h0000_1E0A);

        // R9 read with no responder: error and all-ones data
        respond = 1'b0;
        expect_frame(frm(2'b11, 5'h03, 5'h01, 2'b11, 16'hFFFF), "R9/R5");
        reg_write(2'd1, 32'h8000_0103);
        wait_idle();
        reg_read(2'd0, r); check("R9", {63'b0, r[30]}, 64'h1);
        reg_read(2'd3, r); check("R8", {32'b0, r}, 64'h0000_FFFF);

        // R9 flag cleared by the next read start
        respond = 1'b1; phy_val = 16'h0001;
        expect_frame(frm(2'b11, 5'h03, 5'h01, 2'b10, 16'h0001), "R9/R5");
        reg_write(2'd1, 32'h8000_0103);
        reg_read(2'd0, r); check("R9", {63'b0, r[30]}, 64'h0);
        wait_idle();
        reg_read(2'd0, r); check("R9", {63'b0, r[30]}, 64'h0);
        reg_read(2'd3, r); check("R8", {32'b0, r}, 64'h0000_0001);

        // R6 divider 0 behaves as 1
        reg_write(2'd0, 32'd0);
        expect_frame(frm(2'b01, 5'h03, 5'h01, 2'b10, 16'h8001), "R3/R5");
        reg_write(2'd3, 32'h0000_8001);
        wait_idle();
        check("R6", 64'(int'(last_period)), 64'd40);

        // R10 no stray frames from ignored writes
        repeat (50) @(negedge clk);
        check("R10", 64'(frames_seen), 64'd6);
        check("R10", 64'(exp_q.size()), 64'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule